// File: doc/BRIEF.md
# Duty-Cycled Listen Sequencer

This block steps a radio receiver through a low-power listening cycle. Once it is armed, it alternates between an idle phase and a short receive window. Both phases are timed by a slow tick from a low-frequency oscillator. Each phase length is a coefficient multiplied by a power-of-four resolution unit, and each phase has its own coefficient and its own resolution.

During a receive window the block watches two event strobes: signal strength above threshold, and a sync/address match. When the selected keep-receiving criterion is met, the block holds the receiver on beyond the end of the window. It then waits for payload ready or for a timeout, and afterwards goes back to idle cycling.

Two timers run alongside the phase timer, and both count bit-period ticks in groups of sixteen:
- The start timer aborts a window that sees no signal.
- The signal timer aborts a reception that never completes.

A one-cycle FIFO clear pulse accompanies every wake-up. A one-cycle interrupt pulse marks every timeout.

Top module: `listen_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mode_req` is 0 (standby), and `fifo_clr` and `timeout_irq` are low.
- R2: From standby, the block moves to idle (`mode_req` = 1) on the cycle after a clock edge at which both `listen_en` and `host_stby` are high. With `host_stby` low, it stays in standby.
- R3: Let K = max(coef,1) × 4^res slow ticks, using the idle coefficient and resolution. The idle phase ends on the K-th slow tick seen in idle, and `mode_req` becomes 2 (receive) on the next cycle.
- R4: A receive window lasts K slow ticks, with K computed from the receive coefficient and resolution. If the criterion was not met, the block then returns to idle.
- R5: `fifo_clr` is a one-cycle pulse in the first cycle of every idle-to-receive transition, and at no other time.
- R6: With `keep_sel` = 0, an `rssi_hit` during a window keeps `mode_req` at 2 past the window's end.
- R7: With `keep_sel` = 1, the window is held only when `sync_hit` arrives in the same cycle as, or after, an `rssi_hit`. A sync match alone, or signal alone, lets the window end normally.
- R8: In the held state, `payload_rdy` returns the block to idle on the next cycle without an interrupt.
- R9: If `start_to` = N > 0 and 16·N bit ticks pass in a window with no `rssi_hit`, the block returns to idle and pulses `timeout_irq`. N = 0 disables this timer.
- R10: If `rssi_to` = M > 0 and 16·M bit ticks pass after the cycle of the first `rssi_hit` without the reception finishing, the block returns to idle and pulses `timeout_irq`. M = 0 disables this timer.
- R11: With `listen_en` low, `mode_req` is 0 on the next cycle from any state, and all phase and timeout counts restart from zero on the next entry.
- R12: Same-cycle ordering is as follows:
  - `listen_en` low beats everything.
  - In a window, the criterion beats both timeouts, and a timeout beats the window's end.
  - In the held state, `payload_rdy` beats the signal timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_en | input | 1 | Arms listen cycling; low returns to standby |
| host_stby | input | 1 | High when the host's operating mode is standby |
| slow_tick | input | 1 | One-cycle strobe from the slow oscillator |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| rssi_hit | input | 1 | Signal strength at or above threshold |
| sync_hit | input | 1 | Sync word / address matched |
| payload_rdy | input | 1 | Received packet complete |
| keep_sel | input | 1 | Keep-receiving criterion: 0 signal only, 1 signal then sync |
| idle_coef | input | COEF_W | Idle phase coefficient |
| idle_res | input | RES_W | Idle phase resolution code |
| rx_coef | input | COEF_W | Receive window coefficient |
| rx_res | input | RES_W | Receive window resolution code |
| start_to | input | TO_W | Start timeout, units of 16 bit ticks |
| rssi_to | input | TO_W | Signal timeout, units of 16 bit ticks |
| mode_req | output | 2 | 0 standby, 1 idle, 2 receive |
| fifo_clr | output | 1 | Pulse on each receive wake-up |
| timeout_irq | output | 1 | Pulse on either timeout |

## Verification
The bench first drives regular ticks against quiet event inputs. This separates a correct phase-length product from an off-by-one in either phase count, and it shows whether the wake pulse repeats on every window. Directed scenarios then place signal and sync strobes in different orders and with each one alone. These tell the two criteria apart, and they tell a held window apart from one that simply ends. Timeouts are tried with non-zero and zero limits, so that a disabled timer that still fires shows up as a failure. A long run with random ticks and events makes strobes coincide with window ends and with timer limits; a behavioural model compared every cycle resolves each same-cycle priority.

// File: rtl/listen_sequencer.sv
`timescale 1ns/1ps
module listen_sequencer #(
  parameter int COEF_W   = 8,
  parameter int RES_W    = 2,
  parameter int RES_STEP = 2,
  parameter int TO_W     = 8,
  parameter int TO_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              listen_en,
  input  logic              host_stby,
  input  logic              slow_tick,
  input  logic              bit_tick,
  input  logic              rssi_hit,
  input  logic              sync_hit,
  input  logic              payload_rdy,
  input  logic              keep_sel,
  input  logic [COEF_W-1:0] idle_coef,
  input  logic [RES_W-1:0]  idle_res,
  input  logic [COEF_W-1:0] rx_coef,
  input  logic [RES_W-1:0]  rx_res,
  input  logic [TO_W-1:0]   start_to,
  input  logic [TO_W-1:0]   rssi_to,
  output logic [1:0]        mode_req,
  output logic              fifo_clr,
  output logic              timeout_irq
);
  localparam int PH_W = COEF_W + ((1 << RES_W) - 1) * RES_STEP;
  localparam int TC_W = TO_W + TO_SHIFT;

  typedef enum logic [1:0] {S_STBY = 2'd0, S_IDLE = 2'd1, S_WIN = 2'd2, S_HOLD = 2'd3} st_t;

  st_t             st, nxt;
  logic [PH_W-1:0] ph, ph_lim;
  logic [TC_W-1:0] rxs_cnt, sig_cnt, start_lim, sig_lim;
  logic            seen, in_rx, ph_end, crit, start_fire, sig_fire, wake, fire;

  function automatic logic [PH_W-1:0] span(input logic [COEF_W-1:0] c, input logic [RES_W-1:0] r);
    logic [PH_W-1:0] base;
    base = (c == '0) ? PH_W'(1) : PH_W'(c);
    return base << (int'(r) * RES_STEP);
  endfunction

  assign ph_lim    = (st == S_IDLE) ? span(idle_coef, idle_res) : span(rx_coef, rx_res);
  assign ph_end    = slow_tick && (ph >= ph_lim - PH_W'(1));
  assign in_rx     = (st == S_WIN) || (st == S_HOLD);
  assign start_lim = {start_to, {TO_SHIFT{1'b0}}};
  assign sig_lim   = {rssi_to, {TO_SHIFT{1'b0}}};
  assign crit      = keep_sel ? ((seen || rssi_hit) && sync_hit) : rssi_hit;

  assign start_fire = (st == S_WIN) && (start_to != '0) && bit_tick && !seen && !rssi_hit &&
                      (rxs_cnt >= start_lim - TC_W'(1));
  assign sig_fire   = in_rx && (rssi_to != '0) && bit_tick && seen &&
                      (sig_cnt >= sig_lim - TC_W'(1));

  assign mode_req = (st == S_STBY) ? 2'd0 : (st == S_IDLE) ? 2'd1 : 2'd2;

  always_comb begin
    nxt  = st;
    wake = 1'b0;
    fire = 1'b0;
    if (!listen_en) nxt = S_STBY;
    else begin
      case (st)
        S_STBY: if (host_stby) nxt = S_IDLE;
        S_IDLE: if (ph_end) begin nxt = S_WIN; wake = 1'b1; end
        S_WIN: begin
          if (crit) nxt = S_HOLD;
          else if (start_fire || sig_fire) begin nxt = S_IDLE; fire = 1'b1; end
          else if (ph_end) nxt = S_IDLE;
        end
        default: begin
          if (payload_rdy) nxt = S_IDLE;
          else if (sig_fire) begin nxt = S_IDLE; fire = 1'b1; end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_STBY;
      fifo_clr    <= 1'b0;
      timeout_irq <= 1'b0;
      ph          <= '0;
      rxs_cnt     <= '0;
      sig_cnt     <= '0;
      seen        <= 1'b0;
    end else begin
      st          <= nxt;
      fifo_clr    <= wake;
      timeout_irq <= fire;

      if (nxt != st || st == S_STBY) ph <= '0;
      else if (slow_tick && (st == S_IDLE || st == S_WIN)) ph <= ph + PH_W'(1);

      if (st != S_WIN) rxs_cnt <= '0;
      else if (bit_tick && !seen && !rssi_hit) rxs_cnt <= rxs_cnt + TC_W'(1);

      if (!in_rx) begin
        seen    <= 1'b0;
        sig_cnt <= '0;
      end else if (rssi_hit && !seen) begin
        seen    <= 1'b1;
        sig_cnt <= '0;
      end else if (seen && bit_tick && !sig_fire) begin
        sig_cnt <= sig_cnt + TC_W'(1);
      end
    end
  end

  p_entry_needs_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req == 2'd1 && $past(mode_req) == 2'd0) |-> $past(listen_en && host_stby));

  p_fifo_clr_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> (mode_req == 2'd2 && $past(mode_req) == 2'd1));

  p_pulses_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_clr, timeout_irq}));

  p_payload_ends_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && listen_en && payload_rdy) |=> (mode_req == 2'd1 && !timeout_irq));

  p_irq_from_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> (mode_req == 2'd1 && $past(mode_req) == 2'd2));

  p_hold_has_signal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> seen);

  p_disable_to_stby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !listen_en |=> (mode_req == 2'd0 && !fifo_clr && !timeout_irq));

endmodule

// File: tb/tb_listen_sequencer.sv
`timescale 1ns/1ps
module tb_listen_sequencer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, listen_en = 1'b0, host_stby = 1'b0;
  logic slow_tick = 1'b0, bit_tick = 1'b0;
  logic rssi_hit = 1'b0, sync_hit = 1'b0, payload_rdy = 1'b0, keep_sel = 1'b0;
  logic [7:0] idle_coef = 8'd3, rx_coef = 8'd2, start_to = 8'd0, rssi_to = 8'd0;
  logic [1:0] idle_res = 2'd0, rx_res = 2'd1;
  logic [1:0] mode_req;
  logic fifo_clr, timeout_irq;

  int checks = 0, errors = 0, irq_cnt = 0, clr_cnt = 0, cyc = 0;
  string cur_req = "R1";
  bit tick_run = 0, tick_rand = 0, cmp_on = 0, done = 0;

  listen_sequencer dut (
    .clk(clk), .rst_n(rst_n), .listen_en(listen_en), .host_stby(host_stby),
    .slow_tick(slow_tick), .bit_tick(bit_tick), .rssi_hit(rssi_hit), .sync_hit(sync_hit),
    .payload_rdy(payload_rdy), .keep_sel(keep_sel), .idle_coef(idle_coef), .idle_res(idle_res),
    .rx_coef(rx_coef), .rx_res(rx_res), .start_to(start_to), .rssi_to(rssi_to),
    .mode_req(mode_req), .fifo_clr(fifo_clr), .timeout_irq(timeout_irq));

  function automatic int span_of(int c, int r);
    return ((c == 0) ? 1 : c) * (1 << (2 * r));
  endfunction

  // behavioural reference: 0 standby, 1 idle, 2 window, 3 held
  int m_st = 0, m_ph = 0, m_rxs = 0, m_rc = 0;
  bit m_seen = 0, m_clr = 0, m_irq = 0;

  always @(posedge clk) begin : model
    bit crit, sfire, rfire, wend;
    int len, nst;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_rxs = 0; m_rc = 0; m_seen = 0; m_clr = 0; m_irq = 0;
    end else begin
      m_clr = 0; m_irq = 0;
      len   = (m_st == 1) ? span_of(int'(idle_coef), int'(idle_res)) : span_of(int'(rx_coef), int'(rx_res));
      crit  = keep_sel ? ((m_seen || rssi_hit) && sync_hit) : rssi_hit;
      sfire = (m_st == 2) && start_to != 0 && bit_tick && !m_seen && !rssi_hit && m_rxs >= int'(start_to) * 16 - 1;
      rfire = (m_st >= 2) && rssi_to != 0 && bit_tick && m_seen && m_rc >= int'(rssi_to) * 16 - 1;
      wend  = slow_tick && m_ph >= len - 1;
      nst   = m_st;
      if (!listen_en) nst = 0;
      else if (m_st == 0) begin if (host_stby) nst = 1; end
      else if (m_st == 1) begin if (wend) begin nst = 2; m_clr = 1; end end
      else if (m_st == 2) begin
        if (crit) nst = 3;
        else if (sfire || rfire) begin nst = 1; m_irq = 1; end
        else if (wend) nst = 1;
      end else begin
        if (payload_rdy) nst = 1;
        else if (rfire) begin nst = 1; m_irq = 1; end
      end
      if (m_st >= 2) begin
        if (m_st == 2 && bit_tick && !m_seen && !rssi_hit) m_rxs++;
        if (rssi_hit && !m_seen) begin m_seen = 1; m_rc = 0; end
        else if (m_seen && bit_tick && !rfire) m_rc++;
      end
      if (nst != m_st || m_st == 0) m_ph = 0;
      else if (slow_tick && (m_st == 1 || m_st == 2)) m_ph++;
      if (nst == 2 && m_st == 1) begin m_rxs = 0; m_rc = 0; m_seen = 0; end
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (mode_req != ((m_st >= 2) ? 2'd2 : 2'(m_st)) || fifo_clr != m_clr || timeout_irq != m_irq) begin
        errors++;
        $display("FAIL %s cycle %0d: mode/clr/irq actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                 cur_req, cyc, mode_req, fifo_clr, timeout_irq, (m_st >= 2) ? 2 : m_st, m_clr, m_irq);
      end
    end
    if (timeout_irq) irq_cnt++;
    if (fifo_clr) clr_cnt++;
  end

  always @(negedge clk) begin
    cyc++;
    if (tick_rand) begin
      slow_tick = ($urandom % 6) == 0;
      bit_tick  = ($urandom % 2) == 0;
    end else begin
      slow_tick = tick_run && (cyc % 8 == 0);
      bit_tick  = tick_run && (cyc % 2 == 1);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(int m, int lim);
    int k = 0;
    while (int'(mode_req) != m && k < lim) begin @(negedge clk); k++; end
  endtask

  task automatic pulse_rssi;    rssi_hit = 1;    @(negedge clk); rssi_hit = 0;    endtask
  task automatic pulse_sync;    sync_hit = 1;    @(negedge clk); sync_hit = 0;    endtask
  task automatic pulse_payload; payload_rdy = 1; @(negedge clk); payload_rdy = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int i0;
    step(5);
    check(mode_req == 2'd0 && !fifo_clr && !timeout_irq, "R1", "reset outputs", mode_req, 0);
    rst_n = 1;
    step(1);
    check(mode_req == 2'd0 && !fifo_clr && !timeout_irq, "R1", "after reset", mode_req, 0);
    cmp_on = 1; tick_run = 1;

    cur_req = "R2";
    listen_en = 1; step(30);
    check(mode_req == 2'd0, "R2", "no entry without standby", mode_req, 0);
    host_stby = 1; step(2);
    check(mode_req == 2'd1, "R2", "entry from standby", mode_req, 1);
    host_stby = 0;

    cur_req = "R3"; i0 = clr_cnt;
    step(200);
    cur_req = "R4"; step(200);
    check(clr_cnt - i0 >= 3, "R5", "wake pulses", clr_cnt - i0, 3);

    cur_req = "R6";
    wait_mode(1, 200); wait_mode(2, 200); step(10); pulse_rssi; step(150);
    check(mode_req == 2'd2, "R6", "held past window", mode_req, 2);
    cur_req = "R8"; i0 = irq_cnt; pulse_payload; step(1);
    check(mode_req == 2'd1 && irq_cnt == i0, "R8", "payload ends hold", mode_req, 1);

    cur_req = "R7"; keep_sel = 1;
    wait_mode(2, 200); step(5); pulse_sync; wait_mode(1, 100);
    check(mode_req == 2'd1, "R7", "sync alone not held", mode_req, 1);
    wait_mode(2, 200); step(5); pulse_rssi; wait_mode(1, 100);
    check(mode_req == 2'd1, "R7", "signal alone not held", mode_req, 1);
    wait_mode(2, 200); step(5); pulse_rssi; step(3); pulse_sync; step(150);
    check(mode_req == 2'd2, "R7", "signal then sync held", mode_req, 2);
    pulse_payload;

    cur_req = "R10"; keep_sel = 0; rx_coef = 8'd1; rssi_to = 8'd3;
    wait_mode(1, 200); wait_mode(2, 200); step(5); i0 = irq_cnt; pulse_rssi; step(60);
    check(mode_req == 2'd2, "R10", "held before limit", mode_req, 2);
    step(80);
    check(irq_cnt > i0, "R10", "signal timeout irq", irq_cnt - i0, 1);
    rssi_to = 8'd0;

    cur_req = "R9"; rx_coef = 8'd10; start_to = 8'd2;
    wait_mode(1, 400); wait_mode(2, 400); i0 = irq_cnt; step(200);
    check(irq_cnt > i0, "R9", "start timeout irq", irq_cnt - i0, 1);
    start_to = 8'd0;
    wait_mode(1, 400); wait_mode(2, 400); i0 = irq_cnt; step(300);
    check(irq_cnt == i0 && mode_req == 2'd2, "R9", "zero limit disables", irq_cnt - i0, 0);

    cur_req = "R11";
    listen_en = 0; step(1);
    check(mode_req == 2'd0, "R11", "disable from receive", mode_req, 0);
    listen_en = 1; host_stby = 1; step(1); host_stby = 0; step(5);
    listen_en = 0; step(1);
    check(mode_req == 2'd0, "R11", "disable from idle", mode_req, 0);
    listen_en = 1; host_stby = 1; step(2); host_stby = 0;
    rx_coef = 8'd2;

    cur_req = "R12"; tick_rand = 1;
    for (int seg = 0; seg < 8; seg++) begin
      keep_sel  = seg[0];
      start_to  = 8'(seg % 3);
      rssi_to   = 8'((seg / 2) % 3);
      idle_coef = 8'(seg % 4);
      rx_coef   = 8'(1 + seg % 5);
      rx_res    = 2'(seg % 2);
      for (int k = 0; k < 1500; k++) begin
        rssi_hit    = ($urandom % 25) == 0;
        sync_hit    = ($urandom % 12) == 0;
        payload_rdy = ($urandom % 40) == 0;
        host_stby   = ($urandom % 3) == 0;
        listen_en   = ($urandom % 400) != 0;
        @(negedge clk);
      end
    end
    rssi_hit = 0; sync_hit = 0; payload_rdy = 0;
    step(2);
    check(errors == 0, "R12", "random ordering run", errors, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule